// File: doc/BRIEF.md
# Routed Interrupt Controller

This block collects a bank of interrupt lines (64 by default, or 128) and presents them to a processor as two request outputs: a normal request and a fast request. Every line has its own enable, a choice between edge and level detection, a choice of active sense, and a routing bit that picks which of the two outputs it feeds. Edge requests are held in a sticky pending bit until software acknowledges them. Software can also raise any line by itself.

Software reaches the block through a flat 32-bit register bus with a byte address, a write strobe, write data and combinational read data. Lines are packed 32 to a word. Line n uses bit n mod 32 of the word at byte offset 4*(n/32) inside each per-line bank. The enable can be written whole, or changed bit by bit through a set bank and a clear bank. A two-bit master enable gates each output. A read-only number register gives the lowest pending normal-routed line, or a programmable "nothing pending" value when no such line is pending.

Bank bases (byte offsets): routing 0x000 (1 = fast), enable 0x010, enable-clear 0x020, enable-set 0x030, trigger type 0x040 (1 = edge), polarity 0x050 (1 = falling/low), no-pending value 0x060, master enable 0x064 (bit 0 normal, bit 1 fast), normal status 0x080, fast status 0x090, raw status 0x0A0, acknowledge 0x0B0, software raise 0x0C0, pending number 0x0D0.

Top module: `intc_ctrl`

## Requirements
- R1: After reset, the routing, enable, type, polarity, master enable and no-pending registers read 0, and both request outputs are low.
- R2: Line n is controlled by bit n mod 32 of the word at byte offset 4*(n/32) in each per-line bank.
- R3: Writing 1s to the enable-set bank (0x030) sets those enables. Writing 1s to the enable-clear bank (0x020) clears them. Bits written as 0 in either bank leave the enable unchanged. A write to the enable bank (0x010) replaces the word.
- R4: A level line (type bit 0) shows in raw status (0x0A0) exactly while its input is high when its polarity bit is 0, or low when its polarity bit is 1.
- R5: An edge line (type bit 1) latches a pending bit on a rising input edge when its polarity bit is 0, or on a falling edge when its polarity bit is 1. The bit stays set after the input returns.
- R6: Writing 1 to a line's bit in the acknowledge bank (0x0B0) clears its latched edge request. On an active level line the same write has no effect.
- R7: Changing an edge line to level discards its latched request.
- R8: Writing 1s to the software-raise bank (0x0C0) makes those lines pending in raw status until they are acknowledged through 0x0B0.
- R9: Normal status (0x080) is raw & enable & ~routing, and fast status (0x090) is raw & enable & routing.
- R10: The normal output is high one clock after any normal status bit is set while master bit 0 is set. The fast output is high one clock after any fast status bit is set while master bit 1 is set.
- R11: The pending-number register (0x0D0) returns the lowest-numbered line with its normal status bit set. If no normal status bit is set, it returns the no-pending value written at 0x060.
- R12: An edge detected in the same cycle as an acknowledge write to that line leaves the request latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_lines | input | 32*NUM_WORDS | Interrupt source lines |
| irq_normal_o | output | 1 | Registered normal interrupt request |
| irq_fast_o | output | 1 | Registered fast interrupt request |

## Verification
The assertions assume that the bus makes at most one write per cycle, that the interrupt lines are synchronous to the clock, and that reset is held for at least one edge before any access. The bench meets these by driving every bus and line change on the falling clock edge, and by issuing one write per task call. A change of polarity is itself seen as an edge on an edge line, so the bench sequences line levels, polarity and type so that it only creates an edge where a check expects one.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int WORD_BITS = 32;

    typedef logic [WORD_BITS-1:0] word_t;

    // register bank selected by byte address bits [7:4]
    typedef enum logic [3:0] {
        BK_SEL   = 4'h0,
        BK_EN    = 4'h1,
        BK_ENCLR = 4'h2,
        BK_ENSET = 4'h3,
        BK_TYPE  = 4'h4,
        BK_POL   = 4'h5,
        BK_MISC  = 4'h6,
        BK_NSTAT = 4'h8,
        BK_FSTAT = 4'h9,
        BK_RAW   = 4'hA,
        BK_CLR   = 4'hB,
        BK_SOFT  = 4'hC,
        BK_VEC   = 4'hD
    } bank_e;

    typedef struct packed {
        logic       valid;
        bank_e      bank;
        logic [1:0] word;
        word_t      data;
    } wr_req_t;

    typedef struct packed {
        logic fast;
        logic normal;
    } master_t;

    function automatic logic req_hits(wr_req_t r, bank_e b, int w);
        return r.valid && (r.bank == b) && (int'(r.word) == w);
    endfunction

endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    localparam int NL = NUM_WORDS * WORD_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       req_i,
    output logic [NL-1:0] sel_o,
    output logic [NL-1:0] en_o,
    output logic [NL-1:0] typ_o,
    output logic [NL-1:0] pol_o,
    output master_t       master_o,
    output word_t         nopend_o
);

    word_t sel_q [NUM_WORDS];
    word_t en_q  [NUM_WORDS];
    word_t typ_q [NUM_WORDS];
    word_t pol_q [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[w] <= '0;
                en_q[w]  <= '0;
                typ_q[w] <= '0;
                pol_q[w] <= '0;
            end else if (req_i.valid && int'(req_i.word) == w) begin
                case (req_i.bank)
                    BK_SEL:   sel_q[w] <= req_i.data;
                    BK_EN:    en_q[w]  <= req_i.data;
                    BK_ENCLR: en_q[w]  <= en_q[w] & ~req_i.data;
                    BK_ENSET: en_q[w]  <= en_q[w] | req_i.data;
                    BK_TYPE:  typ_q[w] <= req_i.data;
                    BK_POL:   pol_q[w] <= req_i.data;
                    default:  ;
                endcase
            end
        end

        assign sel_o[w*WORD_BITS +: WORD_BITS] = sel_q[w];
        assign en_o[w*WORD_BITS +: WORD_BITS]  = en_q[w];
        assign typ_o[w*WORD_BITS +: WORD_BITS] = typ_q[w];
        assign pol_o[w*WORD_BITS +: WORD_BITS] = pol_q[w];

        // R3: bits written through the set bank are enabled on the next cycle
        assert_enset_R3: assert property (@(posedge clk) disable iff (rst)
            req_hits(req_i, BK_ENSET, w) |=>
                ((en_q[w] & $past(req_i.data)) == $past(req_i.data)));

        // R3: bits written through the clear bank are disabled on the next cycle
        assert_enclr_R3: assert property (@(posedge clk) disable iff (rst)
            req_hits(req_i, BK_ENCLR, w) |=>
                ((en_q[w] & $past(req_i.data)) == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            master_o <= '0;
            nopend_o <= '0;
        end else begin
            if (req_hits(req_i, BK_MISC, 0)) nopend_o <= req_i.data;
            if (req_hits(req_i, BK_MISC, 1)) master_o <= master_t'(req_i.data[1:0]);
        end
    end

endmodule

// File: rtl/intc_detect.sv
module intc_detect
    import intc_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    localparam int NL = NUM_WORDS * WORD_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] lines_i,
    input  logic [NL-1:0] typ_i,
    input  logic [NL-1:0] pol_i,
    input  wr_req_t       req_i,
    output logic [NL-1:0] raw_o
);

    logic [NL-1:0] act;
    logic [NL-1:0] act_q;
    logic [NL-1:0] edge_now;
    logic [NL-1:0] lat_q;
    logic [NL-1:0] soft_q;
    logic [NL-1:0] clr_m;
    logic [NL-1:0] soft_m;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask
        assign clr_m[w*WORD_BITS +: WORD_BITS]  =
            req_hits(req_i, BK_CLR, w) ? req_i.data : '0;
        assign soft_m[w*WORD_BITS +: WORD_BITS] =
            req_hits(req_i, BK_SOFT, w) ? req_i.data : '0;
    end

    assign act      = lines_i ^ pol_i;
    assign edge_now = act & ~act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            lat_q  <= '0;
            soft_q <= '0;
        end else begin
            act_q  <= act;
            // a new edge wins over a same-cycle acknowledge; level type drops the latch
            lat_q  <= typ_i & ((lat_q & ~clr_m) | edge_now);
            soft_q <= (soft_q & ~clr_m) | soft_m;
        end
    end

    assign raw_o = (typ_i & lat_q) | (~typ_i & act) | soft_q;

    // R5: a latch bit only appears on a line that was edge-typed
    assert_latch_edge_only_R5: assert property (@(posedge clk) disable iff (rst)
        ((lat_q & ~$past(lat_q) & ~$past(typ_i)) == '0));

    // R12: every edge seen on an edge line is latched, acknowledge or not
    assert_edge_kept_R12: assert property (@(posedge clk) disable iff (rst)
        (($past(edge_now & typ_i) & ~lat_q) == '0));

endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int NL = 64,
    localparam int IDX_W = $clog2(NL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NL-1:0]    pend_i,
    output logic             has_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [NL-1:0] ONE = NL'(1);

    always_comb begin
        has_o = 1'b0;
        idx_o = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                has_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // R11: the reported line is pending
    assert_pick_pending_R11: assert property (@(posedge clk) disable iff (rst)
        has_o |-> pend_i[idx_o]);

    // R11: no lower-numbered line is pending
    assert_pick_lowest_R11: assert property (@(posedge clk) disable iff (rst)
        has_o |-> ((pend_i & ((ONE << idx_o) - ONE)) == '0));

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 12,
    localparam int NL       = NUM_WORDS * WORD_BITS,
    localparam int IDX_W    = $clog2(NL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NL-1:0]     irq_lines,
    output logic              irq_normal_o,
    output logic              irq_fast_o
);

    logic          in_range;
    logic          word_ok;
    bank_e         bank;
    logic [1:0]    word;
    wr_req_t       req;

    logic [NL-1:0] sel, en, typ, pol, raw;
    logic [NL-1:0] norm_stat, fast_stat;
    master_t       master;
    word_t         nopend;
    logic          has_pend;
    logic [IDX_W-1:0] pend_idx;

    assign in_range = (bus_addr[ADDR_W-1:8] == '0) && (bus_addr[1:0] == 2'b00);
    assign bank     = bank_e'(bus_addr[7:4]);
    assign word     = bus_addr[3:2];
    assign word_ok  = int'(word) < NUM_WORDS;

    assign req.valid = bus_we && in_range;
    assign req.bank  = bank;
    assign req.word  = word;
    assign req.data  = bus_wdata;

    intc_regs #(.NUM_WORDS(NUM_WORDS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .sel_o    (sel),
        .en_o     (en),
        .typ_o    (typ),
        .pol_o    (pol),
        .master_o (master),
        .nopend_o (nopend)
    );

    intc_detect #(.NUM_WORDS(NUM_WORDS)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .lines_i (irq_lines),
        .typ_i   (typ),
        .pol_i   (pol),
        .req_i   (req),
        .raw_o   (raw)
    );

    assign norm_stat = raw & en & ~sel;
    assign fast_stat = raw & en & sel;

    intc_pick #(.NL(NL)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .pend_i (norm_stat),
        .has_o  (has_pend),
        .idx_o  (pend_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_normal_o <= 1'b0;
            irq_fast_o   <= 1'b0;
        end else begin
            irq_normal_o <= master.normal && (|norm_stat);
            irq_fast_o   <= master.fast && (|fast_stat);
        end
    end

    function automatic word_t slice(input logic [NL-1:0] v, input logic [1:0] w);
        return v[int'(w)*WORD_BITS +: WORD_BITS];
    endfunction

    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            case (bank)
                BK_SEL:   if (word_ok) bus_rdata = slice(sel, word);
                BK_EN:    if (word_ok) bus_rdata = slice(en, word);
                BK_TYPE:  if (word_ok) bus_rdata = slice(typ, word);
                BK_POL:   if (word_ok) bus_rdata = slice(pol, word);
                BK_NSTAT: if (word_ok) bus_rdata = slice(norm_stat, word);
                BK_FSTAT: if (word_ok) bus_rdata = slice(fast_stat, word);
                BK_RAW:   if (word_ok) bus_rdata = slice(raw, word);
                BK_MISC: begin
                    if (word == 2'd0) bus_rdata = nopend;
                    else if (word == 2'd1) bus_rdata = {30'd0, master};
                end
                BK_VEC: begin
                    if (word == 2'd0) bus_rdata = has_pend ? word_t'(pend_idx) : nopend;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R10: a raised normal request needs master bit 0 on the previous cycle
    assert_normal_gate_R10: assert property (@(posedge clk) disable iff (rst)
        irq_normal_o |-> $past(master.normal));

    // R10: a raised fast request needs master bit 1 on the previous cycle
    assert_fast_gate_R10: assert property (@(posedge clk) disable iff (rst)
        irq_fast_o |-> $past(master.fast));

    // R10: no request without status behind it
    assert_normal_cause_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(|norm_stat) |-> !irq_normal_o);

endmodule

// File: tb/intc_ctrl_test.sv
module intc_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 2;
    localparam int NL = NW * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq_lines = '0;
    logic          irq_normal_o;
    logic          irq_fast_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intc_ctrl #(.NUM_WORDS(NW), .ADDR_W(12)) uut (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_lines    (irq_lines),
        .irq_normal_o (irq_normal_o),
        .irq_fast_o   (irq_fast_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h000, v); check("R1 routing", v, 0);
        rd(12'h010, v); check("R1 enable", v, 0);
        rd(12'h044, v); check("R1 type", v, 0);
        rd(12'h050, v); check("R1 polarity", v, 0);
        rd(12'h064, v); check("R1 master", v, 0);
        rd(12'h060, v); check("R1 nopend", v, 0);
        check("R1 outputs", {30'd0, irq_fast_o, irq_normal_o}, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(12'h030, 32'h0000_00F0);
        rd(12'h010, v); check("R3 set", v, 32'h0000_00F0);
        wr(12'h020, 32'h0000_0030);
        rd(12'h010, v); check("R3 clear", v, 32'h0000_00C0);
        wr(12'h030, 32'h0000_0000);
        rd(12'h010, v); check("R3 zero set unchanged", v, 32'h0000_00C0);
        wr(12'h010, 32'h0000_0001);
        rd(12'h010, v); check("R3 direct", v, 32'h0000_0001);
        wr(12'h034, 32'h8000_0000);
        rd(12'h014, v); check("R2 line 63 word1", v, 32'h8000_0000);
        rd(12'h010, v); check("R2 word0 untouched", v, 32'h0000_0001);
        wr(12'h010, 0);
        wr(12'h014, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        @(negedge clk) irq_lines[5] = 1'b1;
        rd(12'h0A0, v); check("R4 active high", v, 32'h20);
        wr(12'h050, 32'h20);
        rd(12'h0A0, v); check("R4 inverted high", v, 0);
        @(negedge clk) irq_lines[5] = 1'b0;
        rd(12'h0A0, v); check("R4 active low", v, 32'h20);
        wr(12'h050, 0);
        @(negedge clk) irq_lines[5] = 1'b1;
        wr(12'h0B0, 32'h20);
        rd(12'h0A0, v); check("R6 level ignores ack", v, 32'h20);
        @(negedge clk) irq_lines[5] = 1'b0;
        rd(12'h0A0, v); check("R4 released", v, 0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(12'h044, 32'h100);                 // line 40 edge
        @(negedge clk) irq_lines[40] = 1'b1;
        tick();
        @(negedge clk) irq_lines[40] = 1'b0;
        rd(12'h0A4, v); check("R5 rising latched", v, 32'h100);
        wr(12'h0B4, 32'h100);
        rd(12'h0A4, v); check("R6 ack clears edge", v, 0);
        @(negedge clk) irq_lines[40] = 1'b1;
        tick();
        @(negedge clk) irq_lines[40] = 1'b0;
        wr(12'h044, 0);
        rd(12'h0A4, v); check("R7 type change drops", v, 0);
        wr(12'h044, 32'h100);
        rd(12'h0A4, v); check("R7 no revival", v, 0);
        @(negedge clk) irq_lines[40] = 1'b1;
        tick();
        wr(12'h0B4, 32'h100);                 // discard rising edge
        wr(12'h054, 32'h100);                 // falling: act goes low, no edge
        rd(12'h0A4, v); check("R5 no edge on high", v, 0);
        @(negedge clk) irq_lines[40] = 1'b0;
        tick();
        @(negedge clk) irq_lines[40] = 1'b1;
        rd(12'h0A4, v); check("R5 falling latched", v, 32'h100);
        wr(12'h044, 0);
        @(negedge clk) irq_lines[40] = 1'b0;
        wr(12'h054, 0);
        rd(12'h0A4, v); check("R5 cleanup", v, 0);
    endtask

    task automatic t_soft();
        logic [31:0] v;
        wr(12'h0C4, 32'h4);                   // line 34
        rd(12'h0A4, v); check("R8 soft raised", v, 32'h4);
        wr(12'h0B4, 32'h4);
        rd(12'h0A4, v); check("R8 soft acked", v, 0);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        wr(12'h010, 32'h88);                  // lines 3,7
        wr(12'h014, 32'h2);                   // line 33
        wr(12'h000, 32'h80);                  // line 7 fast
        wr(12'h0C0, 32'h0010_0088);           // soft 3,7,20
        wr(12'h0C4, 32'h2);                   // soft 33
        rd(12'h080, v); check("R9 normal word0", v, 32'h08);
        rd(12'h084, v); check("R9 normal word1", v, 32'h2);
        rd(12'h090, v); check("R9 fast word0", v, 32'h80);
        rd(12'h0A0, v); check("R9 raw word0", v, 32'h0010_0088);
        check("R10 master off", {30'd0, irq_fast_o, irq_normal_o}, 0);
        wr(12'h064, 32'h1);
        tick();
        check("R10 normal only", {30'd0, irq_fast_o, irq_normal_o}, 32'h1);
        wr(12'h064, 32'h3);
        tick();
        check("R10 both", {30'd0, irq_fast_o, irq_normal_o}, 32'h3);
        rd(12'h0D0, v); check("R11 lowest", v, 3);
        wr(12'h0B0, 32'h8);
        rd(12'h0D0, v); check("R11 next word", v, 33);
        wr(12'h0B4, 32'h2);
        rd(12'h0D0, v); check("R11 nopend default", v, 0);
        tick();
        check("R10 normal fell", {30'd0, irq_fast_o, irq_normal_o}, 32'h2);
        wr(12'h060, 32'h3FF);
        rd(12'h0D0, v); check("R11 nopend value", v, 32'h3FF);
        wr(12'h0B0, 32'h0010_0080);
        tick();
        check("R10 all low", {30'd0, irq_fast_o, irq_normal_o}, 0);
    endtask

    task automatic t_simul();
        logic [31:0] v;
        wr(12'h044, 32'h100);
        @(negedge clk);
        irq_lines[40] = 1'b1;
        bus_addr  = 12'h0B4;
        bus_wdata = 32'h100;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(12'h0A4, v); check("R12 edge beats ack", v, 32'h100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_level();
        t_edge();
        t_soft();
        t_masked();
        t_simul();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule